// File: doc/BRIEF.md
# Prioritized Restart-Vector Interrupt Controller

This block sits beside an 8080-class CPU core and turns up to seven interrupt requests into restart instructions. Each source owns one bit of a request mask. The source raises the bit with a set strobe and drops it with a clear strobe. At every instruction boundary the controller inspects the mask. When the mask holds a request and the CPU's interrupt-enable flag is on, the controller takes the lowest-numbered request. It drives the matching restart opcode for that acknowledge cycle, drops the interrupt-enable flag and wakes a halted CPU.

The controller holds the CPU's interrupt-enable flag, and an EI takes effect one instruction late. It also tracks the halt state and drives both states out for front-panel lamps. A control-port write enables a single-step generator. That generator re-arms the restart-2 request so that exactly one user instruction runs between single-step interrupts. The CPU core is expected to pulse `bnd` before every opcode fetch, and to keep pulsing it while halted so that a pending request can wake the CPU.

Top module: `rst_vec_intc`

## Requirements
- R1: A synchronous active-high reset clears the request mask, the interrupt-enable flag, the halt state and the single-step enable. After reset `run_lamp` is 1 and `ie_lamp`, `ss_on` and `irq_mask` are 0.
- R2: `src_set[i]` sets mask bit i and `src_clr[i]` clears it, one cycle later. When both strobes hit the same bit in the same cycle, the bit ends up set.
- R3: At a boundary with an all-zero mask no interrupt is taken, and `take` stays 0.
- R4: At a boundary with the flag on and the mask non-zero, the lowest set bit i wins. `vec_data` carries 8'b11_NNN_111 with NNN = i+1, so bit 0 gives 8'hCF and bit 6 gives 8'hFF.
- R5: While the interrupt-enable flag is off, no request is taken. Whenever `take` is 0, `vec_data` is 8'h00.
- R6: Taking an interrupt clears the interrupt-enable flag and returns a halted CPU to the running state.
- R7: Taking an interrupt clears the winning bit only if it is bit 0 (clock) or bit 1 (single-step). Bits 2 to 6 stay set until their source clears them.
- R8: `op_ei` makes the flag take effect at the second following boundary, so one instruction completes before any request is taken. `op_di` clears the flag, and any pending EI, at once.
- R9: A write with `port_addr` = 8'hF0 (octal 360) loads `port_data` bit 4 into the single-step enable. Writes to any other address leave it unchanged.
- R10: At a boundary where single-step is enabled, the flag is on and nothing is taken, mask bit 1 is set. Restart 2 (8'hD7) is then taken at the next boundary, after exactly one instruction.
- R11: `op_hlt` moves the CPU to the halted state and `run_lamp` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_set | input | 7 | Per-source request set strobes |
| src_clr | input | 7 | Per-source request clear strobes |
| bnd | input | 1 | Instruction-boundary strobe from the CPU |
| op_ei | input | 1 | EI instruction executed |
| op_di | input | 1 | DI instruction executed |
| op_hlt | input | 1 | HLT instruction executed |
| port_wr | input | 1 | Output-port write strobe |
| port_addr | input | 8 | Output-port address |
| port_data | input | 8 | Output-port write data |
| take | output | 1 | Interrupt taken at this boundary (acknowledge cycle) |
| vec_data | output | 8 | Restart opcode during acknowledge, else zero |
| irq_mask | output | 7 | Current request mask |
| ie_lamp | output | 1 | Interrupt-enable flag |
| run_lamp | output | 1 | CPU running (not halted) |
| ss_on | output | 1 | Single-step enable |

## Verification
Two pairs of functions can act on the same cycle. In the first, a source strobe and the controller's own update hit the same mask bit. The bench provokes this by asserting `src_set` and `src_clr` on one bit together, and judges it by requiring the bit to read set on the next cycle. In the second, the single-step arming and the taking of an interrupt compete at one boundary. The bench walks a handler exit (EI, boundary, boundary) with single-step on and checks the mask after each boundary: nothing is armed while the flag is still off, bit 1 appears after the one user boundary, and 8'hD7 is taken at the boundary after that with no re-arm.

// File: rtl/rst_vec_intc.sv
module rst_vec_intc #(
  parameter int NSRC = 7,
  parameter logic [7:0] CTRL_ADDR = 8'hF0,
  parameter int SS_CTL_BIT = 4,
  parameter int SS_LEVEL = 1,
  parameter logic [NSRC-1:0] SELF_CLR = 7'b0000011
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic            bnd,
  input  logic            op_ei,
  input  logic            op_di,
  input  logic            op_hlt,
  input  logic            port_wr,
  input  logic [7:0]      port_addr,
  input  logic [7:0]      port_data,
  output logic            take,
  output logic [7:0]      vec_data,
  output logic [NSRC-1:0] irq_mask,
  output logic            ie_lamp,
  output logic            run_lamp,
  output logic            ss_on
);

  localparam logic [NSRC-1:0] SS_REQ  = NSRC'(1) << SS_LEVEL;
  localparam logic [7:0]      SS_FLD  = 8'd1 << SS_CTL_BIT;

  logic [NSRC-1:0] mask_q, low_bit, auto_clr, arm_bit;
  logic            ie_q, ei_arm_q, halted_q, ss_en_q, arm, ctl_hit;
  logic [2:0]      vnum;

  assign low_bit = mask_q & (~mask_q + NSRC'(1));

  always_comb begin
    vnum = 3'd0;
    for (int i = 0; i < NSRC; i++)
      if (low_bit[i]) vnum = 3'(i + 1);
  end

  assign take     = bnd & ie_q & (|mask_q);
  assign vec_data = take ? {2'b11, vnum, 3'b111} : 8'h00;
  assign auto_clr = take ? (low_bit & SELF_CLR) : '0;
  assign arm      = bnd & ss_en_q & ie_q & ~take;
  assign arm_bit  = arm ? SS_REQ : '0;
  assign ctl_hit  = port_wr & (port_addr == CTRL_ADDR);

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= (mask_q & ~(src_clr | auto_clr)) | src_set | arm_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q     <= 1'b0;
      ei_arm_q <= 1'b0;
    end else begin
      if (take || op_di)          ie_q <= 1'b0;
      else if (bnd && ei_arm_q)   ie_q <= 1'b1;
      if (op_di)                  ei_arm_q <= 1'b0;
      else if (op_ei)             ei_arm_q <= 1'b1;
      else if (bnd)               ei_arm_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         halted_q <= 1'b0;
    else if (take)   halted_q <= 1'b0;
    else if (op_hlt) halted_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)          ss_en_q <= 1'b0;
    else if (ctl_hit) ss_en_q <= (port_data & SS_FLD) != 8'd0;
  end

  assign irq_mask = mask_q;
  assign ie_lamp  = ie_q;
  assign run_lamp = ~halted_q;
  assign ss_on    = ss_en_q;

endmodule

// File: rtl/rst_vec_intc_chk.sv
module rst_vec_intc_chk #(
  parameter int NSRC = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_set,
  input logic            take,
  input logic [7:0]      vec_data,
  input logic [NSRC-1:0] irq_mask,
  input logic            ie_lamp,
  input logic            run_lamp,
  input logic            ss_on
);

  logic [NSRC-1:0] below;
  logic [2:0]      win;
  assign win   = vec_data[5:3] - 3'd1;
  assign below = (NSRC'(1) << win) - NSRC'(1);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (irq_mask == '0 && !ie_lamp && run_lamp && !ss_on)); // R1

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|src_set) |=> ((irq_mask & $past(src_set)) == $past(src_set))); // R2

  AST_IDLE_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    (irq_mask == '0) |-> !take); // R3

  AST_VEC_FORMAT: assert property (@(posedge clk) disable iff (rst)
    take |-> (vec_data[7:6] == 2'b11 && vec_data[2:0] == 3'b111 && vec_data[5:3] != 3'd0)); // R4

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    take |-> (irq_mask[win] && ((irq_mask & below) == '0))); // R4

  AST_TAKE_WAKES: assert property (@(posedge clk) disable iff (rst)
    take |=> (run_lamp && !ie_lamp)); // R6

endmodule

bind rst_vec_intc rst_vec_intc_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .src_set(src_set), .take(take), .vec_data(vec_data),
  .irq_mask(irq_mask), .ie_lamp(ie_lamp), .run_lamp(run_lamp), .ss_on(ss_on)
);

// File: tb/rst_vec_intc_tb.sv
module rst_vec_intc_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] src_set, src_clr;
  logic       bnd, op_ei, op_di, op_hlt, port_wr;
  logic [7:0] port_addr, port_data;
  logic       take, ie_lamp, run_lamp, ss_on;
  logic [7:0] vec_data;
  logic [6:0] irq_mask;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_vec_intc u_dut (
    .clk(clk), .rst(rst), .src_set(src_set), .src_clr(src_clr), .bnd(bnd),
    .op_ei(op_ei), .op_di(op_di), .op_hlt(op_hlt), .port_wr(port_wr),
    .port_addr(port_addr), .port_data(port_data), .take(take),
    .vec_data(vec_data), .irq_mask(irq_mask), .ie_lamp(ie_lamp),
    .run_lamp(run_lamp), .ss_on(ss_on)
  );

  // {request pattern, expected restart opcode}
  localparam logic [14:0] VECS [9] = '{
    {7'b0000001, 8'hCF}, {7'b0000010, 8'hD7}, {7'b0000100, 8'hDF},
    {7'b1000000, 8'hFF}, {7'b0000110, 8'hD7}, {7'b1010100, 8'hDF},
    {7'b1111111, 8'hCF}, {7'b0100000, 8'hF7}, {7'b0011000, 8'hE7}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    src_clr = '1; tick(); src_clr = '0;
  endtask

  task automatic enable_ie();
    op_ei = 1'b1; tick(); op_ei = 1'b0;
    bnd = 1'b1; tick(); bnd = 1'b0;
  endtask

  task automatic ctl_write(input logic [7:0] a, input logic [7:0] d);
    port_wr = 1'b1; port_addr = a; port_data = d; tick();
    port_wr = 1'b0; port_addr = '0; port_data = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    rst = 1'b1; src_set = '0; src_clr = '0; bnd = 1'b0; op_ei = 1'b0;
    op_di = 1'b0; op_hlt = 1'b0; port_wr = 1'b0; port_addr = '0; port_data = '0;
    tick(); tick();
    check("R1 mask", 32'(irq_mask), 0);
    check("R1 ie", 32'(ie_lamp), 0);
    check("R1 run", 32'(run_lamp), 1);
    check("R1 ss", 32'(ss_on), 0);
    rst = 1'b0;
    tick();

    for (int k = 0; k < 9; k++) begin
      logic [6:0] pat, low, rem;
      pat = VECS[k][14:8];
      low = pat & (~pat + 7'd1);
      rem = ((low & 7'b0000011) != 0) ? (pat & ~low) : pat;
      clear_all();
      enable_ie();
      src_set = pat; tick(); src_set = '0;
      bnd = 1'b1; #1;
      check("R4 take", 32'(take), 1);
      check("R4 vector", 32'(vec_data), 32'(VECS[k][7:0]));
      tick(); bnd = 1'b0;
      check("R7 mask after take", 32'(irq_mask), 32'(rem));
      check("R6 ie cleared", 32'(ie_lamp), 0);
    end

    // R2 set wins over clear
    clear_all();
    src_set = 7'b0001000; src_clr = 7'b0001000; tick();
    src_set = '0; src_clr = '0;
    check("R2 set wins", 32'(irq_mask), 32'h08);
    src_clr = 7'b0001000; tick(); src_clr = '0;
    check("R2 clear", 32'(irq_mask), 0);

    // R3 zero mask
    enable_ie();
    bnd = 1'b1; #1;
    check("R3 no take", 32'(take), 0);
    tick(); bnd = 1'b0;
    check("R3 ie kept", 32'(ie_lamp), 1);

    // R5 bus quiet without boundary, nothing taken with flag off
    src_set = 7'b0010000; tick(); src_set = '0;
    check("R5 idle bus", 32'(vec_data), 0);
    op_di = 1'b1; tick(); op_di = 1'b0;
    check("R8 di", 32'(ie_lamp), 0);
    bnd = 1'b1; #1;
    check("R5 no take ie off", 32'(take), 0);
    check("R5 bus zero", 32'(vec_data), 0);
    tick(); bnd = 1'b0;
    check("R5 mask kept", 32'(irq_mask), 32'h10);

    // R8 EI delay
    op_ei = 1'b1; tick(); op_ei = 1'b0;
    check("R8 not yet", 32'(ie_lamp), 0);
    bnd = 1'b1; #1;
    check("R8 first boundary", 32'(take), 0);
    tick(); bnd = 1'b0;
    check("R8 ie on", 32'(ie_lamp), 1);

    // R11 / R6 halt then wake
    op_hlt = 1'b1; tick(); op_hlt = 1'b0;
    check("R11 halted", 32'(run_lamp), 0);
    bnd = 1'b1; #1;
    check("R6 take wakes", 32'(vec_data), 32'hEF);
    tick(); bnd = 1'b0;
    check("R6 running", 32'(run_lamp), 1);
    check("R7 io bit kept", 32'(irq_mask), 32'h10);
    clear_all();

    // R9 control port
    ctl_write(8'hF1, 8'h10);
    check("R9 other addr", 32'(ss_on), 0);
    ctl_write(8'hF0, 8'h10);
    check("R9 enable", 32'(ss_on), 1);

    // R10 single step after handler exit
    op_ei = 1'b1; tick(); op_ei = 1'b0;
    bnd = 1'b1; #1;
    check("R10 ret boundary", 32'(take), 0);
    tick(); bnd = 1'b0;
    check("R10 no arm yet", 32'(irq_mask), 0);
    bnd = 1'b1; #1;
    check("R10 user boundary", 32'(take), 0);
    tick(); bnd = 1'b0;
    check("R10 armed", 32'(irq_mask), 32'h02);
    bnd = 1'b1; #1;
    check("R10 step vector", 32'(vec_data), 32'hD7);
    tick(); bnd = 1'b0;
    check("R10 disarmed", 32'(irq_mask), 0);
    bnd = 1'b1; tick(); bnd = 1'b0;
    check("R10 no arm ie off", 32'(irq_mask), 0);
    ctl_write(8'hF0, 8'hEF);
    check("R9 disable", 32'(ss_on), 0);

    // R1 reset mid-run
    src_set = 7'b0100001; op_ei = 1'b1; tick(); src_set = '0; op_ei = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    check("R1 reset clears", 32'(irq_mask), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule